// File: doc/BRIEF.md
# Two-Step-Per-Cycle SHA-1 Compression Core

This block runs the SHA-1 compression function on one 512-bit message block. It completes two of the 80 hash steps in every clock cycle. The caller supplies the block and a 160-bit chaining value and raises `start` for one cycle while the core is idle. The core then spends one cycle loading its state and 40 cycles iterating. One further edge adds the working state into the chaining value, registers the result on `digest_out` and pulses `done`. Padding and splitting a message into blocks are the caller's job. For a multi-block message the caller feeds each `digest_out` back as the next `chain_in`.

The datapath is unfolded by two and retimed, so no register holds the A working word. A partial-sum register holds everything of the second step's sum except the rotated first-step result. The live A value is rebuilt as rotl5(B) plus that partial sum. On the loading cycle the partial-sum register holds A directly. Each cycle has one carry-propagate adder per step. The operands that do not depend on the loop are compressed with carry-save stages. A 16-word rolling buffer expands the message schedule and supplies two schedule words per cycle.

Top module: `sha1_pair_core`

## Requirements
- R1: After a synchronous reset, `busy` is 0, `done` is 0 and `digest_out` is all zeros.
- R2: `digest_out` equals the standard SHA-1 compression of `block_in` under `chain_in`. In both chaining values, bits [159:128] carry word H0 and bits [31:0] carry H4. Message word 0 is `block_in[511:480]`, read big-endian.
- R3: A `start` accepted at a clock edge makes `busy` read 1 after that edge. `done` is 1 for exactly one cycle, after the 41st clock edge that follows the accepting edge, and `busy` is 0 while `done` is 1.
- R4: `start` is ignored while a block is in progress, including the final output cycle. A pulse during that time changes neither the result nor its timing.
- R5: `digest_out` holds its value from one completion to the next, and `done` stays 0 between completions.
- R6: A `start` raised in the same cycle that `done` is 1 is accepted. The next result follows with the same 41-edge latency.
- R7: Any chaining value works, not only the standard initial value. Chaining a second block on the first block's digest gives the two-block compression result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; accepted only when idle |
| chain_in | input | 160 | Input chaining value, H0 in the top word |
| block_in | input | 512 | Padded message block, word 0 in the top bits |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| digest_out | output | 160 | Updated chaining value, held until the next completion |

## Verification
A fault in the state registers, the partial-sum register or the rebuilt A word spreads through the remaining steps. At the ports it shows as a digest that is almost entirely wrong, visible when `done` rises 41 edges after acceptance. A fault in the schedule buffer, a round-function boundary or a constant shows only when it meets data that exercises it. So single-bit block sweeps and varied chaining values are compared against an arithmetic model of the compression function. A control fault moves the `done` pulse or lets a mid-run `start` disturb the result. Both are seen at the completion of the affected block.

// File: rtl/sha1_pair_pkg.sv
package sha1_pair_pkg;
  localparam int WORD_W          = 32;
  localparam int NUM_WORDS       = 5;
  localparam int STATE_W         = WORD_W * NUM_WORDS;
  localparam int SCHED_DEPTH     = 16;
  localparam int BLOCK_W         = WORD_W * SCHED_DEPTH;
  localparam int STEPS           = 80;
  localparam int STEPS_PER_CYCLE = 2;
  localparam int PAIRS           = STEPS / STEPS_PER_CYCLE;
  localparam int ROUND_LEN       = 20;
  localparam int PAIRS_PER_ROUND = ROUND_LEN / STEPS_PER_CYCLE;
  localparam int CNT_W           = $clog2(PAIRS);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    FN_CHOOSE = 2'd0,
    FN_XOR_LO = 2'd1,
    FN_MAJOR  = 2'd2,
    FN_XOR_HI = 2'd3
  } rnd_e;

  typedef struct packed {
    word_t s;
    word_t c;
  } csa_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t mix_fn(input rnd_e r, input word_t x, input word_t y, input word_t z);
    case (r)
      FN_CHOOSE: return (x & y) | (~x & z);
      FN_MAJOR:  return (x & y) | (x & z) | (y & z);
      default:   return x ^ y ^ z;
    endcase
  endfunction

  function automatic word_t rnd_const(input rnd_e r);
    case (r)
      FN_CHOOSE: return 32'h5A827999;
      FN_XOR_LO: return 32'h6ED9EBA1;
      FN_MAJOR:  return 32'h8F1BBCDC;
      default:   return 32'hCA62C1D6;
    endcase
  endfunction

  function automatic csa_t csa3(input word_t x, input word_t y, input word_t z);
    csa_t r;
    r.s = x ^ y ^ z;
    r.c = ((x & y) | (x & z) | (y & z)) << 1;
    return r;
  endfunction
endpackage

// File: rtl/sha1_msg_sched.sv
module sha1_msg_sched
  import sha1_pair_pkg::*;
(
  input  logic               clk,
  input  logic               load,
  input  logic               shift,
  input  logic [BLOCK_W-1:0] block,
  output word_t              w_even,
  output word_t              w_odd
);
  word_t win_q [SCHED_DEPTH];
  word_t nx_a, nx_b;

  // Two new schedule words per cycle, both from the old window only.
  assign nx_a = rotl(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
  assign nx_b = rotl(win_q[14] ^ win_q[9] ^ win_q[3] ^ win_q[1], 1);

  genvar gi;
  generate
    for (gi = 0; gi < SCHED_DEPTH; gi++) begin : g_win
      always_ff @(posedge clk) begin
        if (load) begin
          win_q[gi] <= block[BLOCK_W-1-WORD_W*gi -: WORD_W];
        end else if (shift) begin
          if (gi < SCHED_DEPTH - 2)       win_q[gi] <= win_q[gi+2];
          else if (gi == SCHED_DEPTH - 2) win_q[gi] <= nx_a;
          else                            win_q[gi] <= nx_b;
        end
      end
    end
  endgenerate

  assign w_even = win_q[0];
  assign w_odd  = win_q[1];
endmodule

// File: rtl/sha1_step_pair.sv
module sha1_step_pair
  import sha1_pair_pkg::*;
(
  input  rnd_e  rnd,
  input  word_t a_in,
  input  word_t b_in,
  input  word_t c_in,
  input  word_t d_in,
  input  word_t e_in,
  input  word_t w_even,
  input  word_t w_odd,
  output word_t b_nx,
  output word_t c_nx,
  output word_t d_nx,
  output word_t e_nx,
  output word_t t1_nx
);
  word_t k, f_even, f_odd, b_rot;
  csa_t  p0, p1, p2, q0, q1;

  assign k      = rnd_const(rnd);
  assign b_rot  = rotl(b_in, 30);
  assign f_even = mix_fn(rnd, b_in, c_in, d_in);
  assign f_odd  = mix_fn(rnd, a_in, b_rot, c_in);

  // First step: carry-save compression, single carry-propagate adder.
  assign p0   = csa3(e_in, k, w_even);
  assign p1   = csa3(p0.s, p0.c, f_even);
  assign p2   = csa3(p1.s, p1.c, rotl(a_in, 5));
  assign b_nx = p2.s + p2.c;

  // Second step without rotl5 of the first result (added next cycle).
  assign q0    = csa3(d_in, k, w_odd);
  assign q1    = csa3(q0.s, q0.c, f_odd);
  assign t1_nx = q1.s + q1.c;

  assign c_nx = rotl(a_in, 30);
  assign d_nx = b_rot;
  assign e_nx = c_in;
endmodule

// File: rtl/sha1_pair_core.sv
module sha1_pair_core
  import sha1_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [STATE_W-1:0] chain_in,
  input  logic [BLOCK_W-1:0] block_in,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] digest_out
);
  localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(PAIRS - 1);
  localparam logic [CNT_W-1:0] BOUND1    = CNT_W'(PAIRS_PER_ROUND);
  localparam logic [CNT_W-1:0] BOUND2    = CNT_W'(2 * PAIRS_PER_ROUND);
  localparam logic [CNT_W-1:0] BOUND3    = CNT_W'(3 * PAIRS_PER_ROUND);

  logic [CNT_W-1:0]   pair_q;
  logic               busy_q, first_q, fin_q;
  word_t              b_q, c_q, d_q, e_q, t1_q;
  logic [STATE_W-1:0] chain_q;
  word_t              a_cur, w_even, w_odd;
  word_t              b_nx, c_nx, d_nx, e_nx, t1_nx;
  rnd_e               rnd;
  logic               accept;

  assign accept = start && !busy_q && !fin_q;
  assign a_cur  = first_q ? t1_q : rotl(b_q, 5) + t1_q;

  always_comb begin
    if (pair_q < BOUND1)      rnd = FN_CHOOSE;
    else if (pair_q < BOUND2) rnd = FN_XOR_LO;
    else if (pair_q < BOUND3) rnd = FN_MAJOR;
    else                      rnd = FN_XOR_HI;
  end

  sha1_msg_sched i_sched (
    .clk    (clk),
    .load   (accept),
    .shift  (busy_q),
    .block  (block_in),
    .w_even (w_even),
    .w_odd  (w_odd)
  );

  sha1_step_pair i_pair (
    .rnd    (rnd),
    .a_in   (a_cur),
    .b_in   (b_q),
    .c_in   (c_q),
    .d_in   (d_q),
    .e_in   (e_q),
    .w_even (w_even),
    .w_odd  (w_odd),
    .b_nx   (b_nx),
    .c_nx   (c_nx),
    .d_nx   (d_nx),
    .e_nx   (e_nx),
    .t1_nx  (t1_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      first_q    <= 1'b0;
      fin_q      <= 1'b0;
      pair_q     <= '0;
      done       <= 1'b0;
      digest_out <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        first_q <= 1'b1;
        pair_q  <= '0;
      end else if (busy_q) begin
        first_q <= 1'b0;
        pair_q  <= pair_q + 1'b1;
        if (pair_q == LAST_PAIR) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end else if (fin_q) begin
        fin_q      <= 1'b0;
        done       <= 1'b1;
        digest_out <= {chain_q[159:128] + a_cur, chain_q[127:96] + b_q,
                       chain_q[95:64] + c_q, chain_q[63:32] + d_q,
                       chain_q[31:0] + e_q};
      end
    end
  end

  // Working state has no reset: it is always loaded before use.
  always_ff @(posedge clk) begin
    if (accept) begin
      chain_q <= chain_in;
      t1_q    <= chain_in[159:128];
      b_q     <= chain_in[127:96];
      c_q     <= chain_in[95:64];
      d_q     <= chain_in[63:32];
      e_q     <= chain_in[31:0];
    end else if (busy_q) begin
      t1_q <= t1_nx;
      b_q  <= b_nx;
      c_q  <= c_nx;
      d_q  <= d_nx;
      e_q  <= e_nx;
    end
  end

  assign busy = busy_q;

  assert_accept_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_q && pair_q == '0));
  assert_last_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && pair_q == LAST_PAIR) |=> (!busy_q && !done));
  assert_finish_R3: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> done);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy_q);
  assert_ignore_start_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && pair_q != LAST_PAIR) |=> (busy_q && pair_q == $past(pair_q) + 1'b1));
  assert_digest_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(digest_out) |-> done);
endmodule

// File: tb/test_sha1_pair_core.sv
`timescale 1ns/1ps
module test_sha1_pair_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [159:0] chain_in = '0;
  logic [511:0] block_in = '0;
  logic         busy, done;
  logic [159:0] digest_out;

  int checks = 0;
  int failures = 0;

  localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  always #5 clk = ~clk;

  sha1_pair_core i_sha1_pair_core (
    .clk(clk), .rst(rst), .start(start), .chain_in(chain_in),
    .block_in(block_in), .busy(busy), .done(done), .digest_out(digest_out)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_compress(input logic [159:0] h, input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, tmp;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      tmp = rl(a, 5) + f + e + w[t] + k;
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic check(input logic ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; raises start there. Returns at the negedge where done is seen.
  task automatic run_block(input logic [159:0] h, input logic [511:0] blk,
                           input bit disturb, input string req, output logic [159:0] res);
    int k;
    logic [159:0] exp;
    exp = ref_compress(h, blk);
    chain_in = h; block_in = blk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    check(busy == 1'b1, "R3 busy after accept", {159'd0, busy}, 160'd1);
    while (!done && k < 100) begin
      if (disturb && (k == 7 || k == 40)) begin
        // R4: foreign start pulses mid-run and in the output-wait cycle
        chain_in = ~h; block_in = ~blk; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    check(k == 41, "R3 done latency", 160'(k), 160'd41);
    check(busy == 1'b0, "R3 busy low with done", {159'd0, busy}, 160'd0);
    check(digest_out == exp, req, digest_out, exp);
    res = digest_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [159:0] r, r1, held;
    logic [511:0] abc, blk;
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {158'd0, busy, done}, 160'd0);
    check(digest_out == '0, "R1 reset digest", digest_out, 160'd0);
    rst = 1'b0;
    @(negedge clk);

    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0] = 32'h18;
    run_block(IV, abc, 1'b0, "R2 abc model", r);
    check(r == 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D, "R2 abc known digest",
          r, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);

    held = digest_out;
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R5 done stays low", {159'd0, done}, 160'd0);
    check(digest_out == held, "R5 digest held", digest_out, held);

    run_block(IV, '0, 1'b0, "R2 zero block", r);
    run_block(IV, {512{1'b1}}, 1'b0, "R2 ones block", r);
    run_block(IV, abc, 1'b1, "R4 start ignored", r);

    // R7: chain second block on the first result, then arbitrary chains
    run_block(IV, '0, 1'b0, "R7 first of pair", r1);
    run_block(r1, abc, 1'b0, "R7 chained block", r);
    run_block('0, abc, 1'b0, "R7 zero chain", r);

    // R6: the calls below start in the cycle done is high (back to back)
    for (int i = 0; i < 32; i++) begin
      blk = '0;
      blk[i * 16 + (i % 16)] = 1'b1;
      run_block(IV, blk, 1'b0, "R6 R2 single-bit sweep", r);
    end

    seed = 32'h1234_5678;
    for (int n = 0; n < 8; n++) begin
      logic [159:0] h;
      for (int j = 0; j < 16; j++) begin seed = xs(seed); blk[511-32*j -: 32] = seed; end
      for (int j = 0; j < 5; j++)  begin seed = xs(seed); h[159-32*j -: 32] = seed; end
      run_block(h, blk, n[0], "R7 R2 random chain and block", r);
    end

    repeat (3) @(negedge clk);
    check(done == 1'b0, "R5 quiet after burst", {159'd0, done}, 160'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule